// File: doc/BRIEF.md
# DRAM Strobe Decoder with Refresh Counter

This block is the device side of a scaled-down asynchronous DRAM, meant as a synthesizable stand-in for a memory behind a strobe-driven controller. The five active-low control strobes, the multiplexed address bus and the write data are sampled on a fast system clock. Each input passes through a two-flop synchronizer. Falling and rising strobe edges are found by comparing the synchronized level with a registered copy of it.

The row is captured when the row strobe falls. The column is taken from the address bus on every column-strobe fall while the row strobe is low. The order of the two strobes sets the cycle type:
- A row-strobe fall with both column strobes high opens a page. That page serves early writes, reads and further fast-page accesses.
- If no column access happens before the row strobe rises, the cycle is reported as a refresh of the captured row.
- A row-strobe fall while a column strobe is already low is a counter refresh. It uses an internal row counter and ignores the address bus.

Hidden refresh works in the usual way: the column strobe is held low after a read and the row strobe is cycled. A small register array, folded onto the low row and column bits, holds the data.

Top module: `dram_strobe_if`

## Requirements
- R1: After reset, `dout_en` is 00, `proto_err` is 0, `rfsh_ctr` is 0 and no `rfsh_evt` pulse has occurred.
- R2: A row is captured from `addr` when `ras_n` falls with both column strobes high. The column is captured from `addr` when a column strobe falls during that row cycle. The stored word sits at index {row[2:0], col[2:0]} with the default sizes. All 64 words read as 0 after reset.
- R3: If `we_n` is low at a column-strobe fall, only the byte lanes whose column strobe is low are written. Lane 0 is `din[7:0]` with `cas_lo_n`; lane 1 is `din[15:8]` with `cas_hi_n`. `dout_en` is 00 after the write.
- R4: If `we_n` is high at a column-strobe fall, the addressed word appears on `dout`. `dout_en[i]` is 1 exactly when lane i's column strobe is low and `oe_n` is low.
- R5: While `ras_n` stays low, every further column-strobe fall accesses a new column of the same row.
- R6: If `ras_n` rises and no column strobe fell during the row cycle, one single-cycle `rfsh_evt` is issued with `rfsh_cbr`=0 and `rfsh_row` equal to the captured row. `rfsh_ctr` does not change.
- R7: If `ras_n` falls while either column strobe is low, one `rfsh_evt` is issued with `rfsh_cbr`=1 and `rfsh_row` equal to the counter value before the event. The counter then advances by one, modulo 2^13. Memory and `addr` play no part in this cycle.
- R8: If the column strobes stay low after a read while `ras_n` rises and falls again, a counter refresh is performed and `dout_en` and `dout` keep the read word throughout. `dout_en` returns to 00 only once both column strobes are high.
- R9: `proto_err` sets when a column strobe that fell with `ras_n` high rises again before `ras_n` falls. It stays set until the next `ras_n` fall clears it. A normal counter refresh never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_lo_n | input | 1 | Column strobe, lower byte lane |
| cas_hi_n | input | 1 | Column strobe, upper byte lane |
| we_n | input | 1 | Write select, low at column fall means write |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 16 | Write data |
| dout | output | 16 | Read data |
| dout_en | output | 2 | Per-lane data-out enable (1 = drive) |
| rfsh_evt | output | 1 | One-cycle pulse per completed refresh |
| rfsh_cbr | output | 1 | Kind of last refresh: 1 counter, 0 row-only |
| rfsh_row | output | ADDR_W | Row refreshed by the last event |
| rfsh_ctr | output | ADDR_W | Internal refresh row counter |
| proto_err | output | 1 | Sticky column-without-row error flag |

## Verification
The bench targets the cases that depend on strobe order:
- **Row strobe rising with the column strobes still low.** A decoder that ignores this would report a false row-only refresh or drop the read data during a hidden refresh.
- **Column strobes already low when the row strobe falls.** A decoder that misses this would open a page at the address pins instead of refreshing the counter row.
- **Single-lane writes.** A wrong lane mask would corrupt the untouched byte.
- **Column pulses with no row strobe.** These must raise `proto_err`, while a proper counter refresh must not.

Random page cycles with several fast-page accesses are compared against a bench memory model, so a wrong index fold or a stale column latch shows up as wrong read data.

// File: rtl/dram_if_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the DRAM strobe decoder.
// Assumes two byte lanes of eight bits each.
package dram_if_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    // Phase of the row-strobe cycle as seen by the controller.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,  // row strobe high
        PH_OPEN = 2'd1,  // page open after a plain row-strobe fall
        PH_RFSH = 2'd2   // counter refresh in progress
    } phase_e;
endpackage

// File: rtl/sync_bus.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a bus of asynchronous inputs.
// Assumes a multi-bit bus is held stable for several clocks around any
// strobe edge, so skew between bits is harmless.
module sync_bus #(
    parameter int        W       = 1,
    parameter logic      RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two register stages toward the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= {W{RST_VAL}};
            q      <= {W{RST_VAL}};
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/edge_track.sv
`timescale 1ns/1ps
// Edge finder for synchronized active-low strobes.
// Assumes its input is already synchronous. Resets to the inactive level,
// so reset release never produces a false edge.
module edge_track #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] fall,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    // Keep last cycle's level for the comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= {W{1'b1}};
        else        prev_q <= lvl;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign fall[i] = prev_q[i] & ~lvl[i];
        assign rise[i] = ~prev_q[i] & lvl[i];
    end
endmodule

// File: rtl/cycle_ctrl.sv
`timescale 1ns/1ps
// Cycle decoder of the DRAM stand-in.
// Takes the synchronized strobe levels and edges. Decides from the order of
// row and column edges whether a cycle opens a page, refreshes the captured
// row, or refreshes the counter row. Issues array accesses and lane output
// enables.
// Assumes a row and a column edge never land in the same synchronized cycle.
module cycle_ctrl
    import dram_if_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_fall,
    input  logic                ras_rise,
    input  logic [LANES-1:0]    cas_lvl,
    input  logic [LANES-1:0]    cas_fall,
    input  logic [LANES-1:0]    cas_rise,
    input  logic                we_lvl,
    input  logic                oe_lvl,
    input  logic [ADDR_W-1:0]   addr,
    output logic [ROW_BITS-1:0] acc_row,
    output logic [COL_BITS-1:0] acc_col,
    output logic [LANES-1:0]    wr_lanes,
    output logic                rd_go,
    output logic [LANES-1:0]    lane_en,
    output logic                rfsh_evt,
    output logic                rfsh_cbr,
    output logic [ADDR_W-1:0]   rfsh_row,
    output logic [ADDR_W-1:0]   rfsh_ctr,
    output logic                proto_err
);
    phase_e              phase_q;
    logic [ADDR_W-1:0]   row_q;
    logic [ADDR_W-1:0]   ctr_q;
    logic [LANES-1:0]    armed_q;
    logic                used_q;
    logic                hold_q;
    logic                page_hit;
    logic                all_high;

    assign all_high = &cas_lvl;
    // A column edge inside an open page that is not closing this cycle.
    assign page_hit = (phase_q == PH_OPEN) && !ras_rise && (|cas_fall);

    // Array access requests, taken in the cycle the column edge is seen.
    always_comb begin
        acc_row  = row_q[ROW_BITS-1:0];
        acc_col  = addr[COL_BITS-1:0];
        wr_lanes = (page_hit && !we_lvl) ? ~cas_lvl : '0;
        rd_go    = page_hit && we_lvl;
    end

    // Lane enables: read word held while its strobe and output enable are low.
    for (genvar l = 0; l < LANES; l++) begin : g_en
        assign lane_en[l] = hold_q & ~oe_lvl & ~cas_lvl[l];
    end

    // Phase sequencing, refresh reporting, counter and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            row_q     <= '0;
            ctr_q     <= '0;
            armed_q   <= '0;
            used_q    <= 1'b0;
            rfsh_evt  <= 1'b0;
            rfsh_cbr  <= 1'b0;
            rfsh_row  <= '0;
            proto_err <= 1'b0;
        end else begin
            rfsh_evt <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (ras_fall) begin
                        armed_q   <= '0;
                        proto_err <= 1'b0;
                        if (!all_high) begin
                            rfsh_evt <= 1'b1;
                            rfsh_cbr <= 1'b1;
                            rfsh_row <= ctr_q;
                            ctr_q    <= ctr_q + 1'b1;
                            phase_q  <= PH_RFSH;
                        end else begin
                            row_q   <= addr;
                            used_q  <= 1'b0;
                            phase_q <= PH_OPEN;
                        end
                    end else begin
                        if (|(cas_rise & armed_q)) proto_err <= 1'b1;
                        armed_q <= (armed_q & ~cas_rise) | cas_fall;
                    end
                end
                PH_OPEN: begin
                    if (ras_rise) begin
                        phase_q <= PH_IDLE;
                        if (!used_q) begin
                            rfsh_evt <= 1'b1;
                            rfsh_cbr <= 1'b0;
                            rfsh_row <= row_q;
                        end
                    end else if (page_hit) begin
                        used_q <= 1'b1;
                    end
                end
                PH_RFSH: begin
                    if (ras_rise) phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Read-hold flag: set by a read, cleared by a write or by both strobes high.
    always_ff @(posedge clk) begin
        if (!rst_n)              hold_q <= 1'b0;
        else if (|wr_lanes)      hold_q <= 1'b0;
        else if (rd_go)          hold_q <= 1'b1;
        else if (all_high)       hold_q <= 1'b0;
    end

    assign rfsh_ctr = ctr_q;
endmodule

// File: rtl/store_array.sv
`timescale 1ns/1ps
// Small register array standing in for the cell matrix.
// One memory per byte lane, each written under its own lane enable. Read
// data is registered on a read request and held until the next read. Clears
// to zero on reset.
module store_array
    import dram_if_pkg::*;
#(
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ROW_BITS-1:0] row,
    input  logic [COL_BITS-1:0] col,
    input  logic [LANES-1:0]    wr_lanes,
    input  logic                rd_go,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata
);
    localparam int IDX_W = ROW_BITS + COL_BITS;
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0] idx;
    assign idx = {row, col};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cell_q [DEPTH];

        // Lane storage: clear on reset, byte write when the lane is enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < DEPTH; k++) cell_q[k] <= '0;
            end else if (wr_lanes[l]) begin
                cell_q[idx] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        // Lane read register, loaded on a read request.
        always_ff @(posedge clk) begin
            if (!rst_n)     rdata[l*LANE_W +: LANE_W] <= '0;
            else if (rd_go) rdata[l*LANE_W +: LANE_W] <= cell_q[idx];
        end
    end
endmodule

// File: rtl/dram_strobe_if.sv
`timescale 1ns/1ps
// Top of the DRAM strobe decoder.
// Synchronizes strobes, address and data; finds strobe edges; decodes the
// cycle type; and drives a small storage array.
// Assumes strobes stay stable for at least three clocks between edges.
module dram_strobe_if
    import dram_if_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_lo_n,
    input  logic              cas_hi_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       din,
    output logic [15:0]       dout,
    output logic [1:0]        dout_en,
    output logic              rfsh_evt,
    output logic              rfsh_cbr,
    output logic [ADDR_W-1:0] rfsh_row,
    output logic [ADDR_W-1:0] rfsh_ctr,
    output logic              proto_err
);
    localparam int STB_W = 5;
    localparam int BUS_W = ADDR_W + DATA_W;

    logic [STB_W-1:0]    stb_s;
    logic [BUS_W-1:0]    bus_s;
    logic                ras_s;
    logic [LANES-1:0]    cas_s;
    logic                we_s;
    logic                oe_s;
    logic [ADDR_W-1:0]   addr_s;
    logic [DATA_W-1:0]   din_s;
    logic [2:0]          fall_v;
    logic [2:0]          rise_v;
    logic [ROW_BITS-1:0] acc_row;
    logic [COL_BITS-1:0] acc_col;
    logic [LANES-1:0]    wr_lanes;
    logic                rd_go;

    sync_bus #(.W(STB_W), .RST_VAL(1'b1)) u_sync_stb (
        .clk(clk), .rst_n(rst_n),
        .d({oe_n, we_n, cas_hi_n, cas_lo_n, ras_n}),
        .q(stb_s)
    );

    sync_bus #(.W(BUS_W), .RST_VAL(1'b0)) u_sync_bus (
        .clk(clk), .rst_n(rst_n),
        .d({din, addr}),
        .q(bus_s)
    );

    assign ras_s  = stb_s[0];
    assign cas_s  = stb_s[2:1];
    assign we_s   = stb_s[3];
    assign oe_s   = stb_s[4];
    assign addr_s = bus_s[ADDR_W-1:0];
    assign din_s  = bus_s[BUS_W-1:ADDR_W];

    edge_track #(.W(3)) u_edges (
        .clk(clk), .rst_n(rst_n),
        .lvl({cas_s, ras_s}),
        .fall(fall_v),
        .rise(rise_v)
    );

    cycle_ctrl #(.ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ras_fall(fall_v[0]), .ras_rise(rise_v[0]),
        .cas_lvl(cas_s), .cas_fall(fall_v[2:1]), .cas_rise(rise_v[2:1]),
        .we_lvl(we_s), .oe_lvl(oe_s), .addr(addr_s),
        .acc_row(acc_row), .acc_col(acc_col),
        .wr_lanes(wr_lanes), .rd_go(rd_go), .lane_en(dout_en),
        .rfsh_evt(rfsh_evt), .rfsh_cbr(rfsh_cbr), .rfsh_row(rfsh_row),
        .rfsh_ctr(rfsh_ctr), .proto_err(proto_err)
    );

    store_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .row(acc_row), .col(acc_col),
        .wr_lanes(wr_lanes), .rd_go(rd_go),
        .wdata(din_s), .rdata(dout)
    );
endmodule

// File: rtl/dram_strobe_if_chk.sv
`timescale 1ns/1ps
// Property checker for the DRAM strobe decoder, bound to the top module.
module dram_strobe_if_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_s,
    input logic [1:0]        wr_lanes,
    input logic [1:0]        dout_en,
    input logic              rfsh_evt,
    input logic              rfsh_cbr,
    input logic [ADDR_W-1:0] rfsh_ctr,
    input logic              proto_err
);
    p_ctr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_evt && rfsh_cbr) |-> (rfsh_ctr == ADDR_W'($past(rfsh_ctr) + 1'b1)));

    p_ctr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rfsh_evt && rfsh_cbr) |-> $stable(rfsh_ctr));

    p_wr_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lanes != 2'b00) |=> (dout_en == 2'b00));

    p_evt_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_evt |=> !rfsh_evt);

    p_err_ras_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err) |-> ras_s);
endmodule

bind dram_strobe_if dram_strobe_if_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_s(ras_s), .wr_lanes(wr_lanes),
    .dout_en(dout_en), .rfsh_evt(rfsh_evt), .rfsh_cbr(rfsh_cbr),
    .rfsh_ctr(rfsh_ctr), .proto_err(proto_err)
);

// File: tb/test_dram_strobe_if.sv
`timescale 1ns/1ps
module test_dram_strobe_if;
    localparam int AW = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_lo_n = 1'b1, cas_hi_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   din = '0;
    logic [15:0]   dout;
    logic [1:0]    dout_en;
    logic          rfsh_evt, rfsh_cbr, proto_err;
    logic [AW-1:0] rfsh_row, rfsh_ctr;

    int checks = 0, fails = 0;
    int ev_cnt = 0;
    logic          ev_cbr;
    logic [AW-1:0] ev_row;
    logic [15:0]   model [64];
    logic [AW-1:0] cur_row;
    bit            done = 0;

    always #2.5 clk = ~clk;

    dram_strobe_if i_dram_strobe_if (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_lo_n(cas_lo_n),
        .cas_hi_n(cas_hi_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .rfsh_evt(rfsh_evt), .rfsh_cbr(rfsh_cbr),
        .rfsh_row(rfsh_row), .rfsh_ctr(rfsh_ctr), .proto_err(proto_err)
    );

    // Refresh event monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && rfsh_evt) begin
            ev_cnt <= ev_cnt + 1;
            ev_cbr <= rfsh_cbr;
            ev_row <= rfsh_row;
        end
    end

    function automatic logic [15:0] lane_mask(logic [1:0] l);
        return {{8{l[1]}}, {8{l[0]}}};
    endfunction

    function automatic int widx(logic [AW-1:0] r, logic [AW-1:0] c);
        return int'({r[2:0], c[2:0]});
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ras_open(logic [AW-1:0] r);
        addr = r; cur_row = r; ras_n = 1'b0; settle(4);
    endtask

    task automatic ras_close();
        ras_n = 1'b1; settle(4);
    endtask

    task automatic cas_release();
        cas_lo_n = 1'b1; cas_hi_n = 1'b1; settle(4);
    endtask

    // One column access inside an open page, checked against the model.
    task automatic access(string req, logic [AW-1:0] c, logic [1:0] lanes,
                          logic wr, logic oe_low, logic [15:0] data);
        int k;
        k = widx(cur_row, c);
        addr = c; din = data; we_n = ~wr; oe_n = ~oe_low;
        cas_lo_n = ~lanes[0]; cas_hi_n = ~lanes[1];
        settle(4);
        if (wr) begin
            model[k] = (model[k] & ~lane_mask(lanes)) | (data & lane_mask(lanes));
            chk({req, " write hi-Z"}, 32'(dout_en), 32'd0);
        end else begin
            chk({req, " read enables"}, 32'(dout_en), oe_low ? 32'(lanes) : 32'd0);
            chk({req, " read data"}, 32'(dout & lane_mask(lanes)),
                32'(model[k] & lane_mask(lanes)));
        end
        cas_release();
        we_n = 1'b1;
    endtask

    initial begin
        int ev0;
        logic [AW-1:0] ctr0;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 64; i++) model[i] = '0;
        settle(5);
        rst_n = 1'b1;
        settle(3);

        // R1: reset state
        chk("R1 dout_en", 32'(dout_en), 0);
        chk("R1 proto_err", 32'(proto_err), 0);
        chk("R1 rfsh_ctr", 32'(rfsh_ctr), 0);
        chk("R1 no events", ev_cnt, 0);

        // R2 R3 R4: word write then reads with lane and output-enable variants
        ras_open(13'h0a5);
        access("R2 word", 13'h003, 2'b11, 1'b1, 1'b1, 16'hbeef);
        access("R2 word", 13'h003, 2'b11, 1'b0, 1'b1, 16'h0);
        access("R3 lower only", 13'h003, 2'b01, 1'b1, 1'b1, 16'h1234);
        access("R3 upper kept", 13'h003, 2'b11, 1'b0, 1'b1, 16'h0);
        access("R4 lower lane", 13'h003, 2'b01, 1'b0, 1'b1, 16'h0);
        access("R4 upper lane", 13'h003, 2'b10, 1'b0, 1'b1, 16'h0);
        access("R4 oe high", 13'h003, 2'b11, 1'b0, 1'b0, 16'h0);
        // R5: fast page, second column in the same row
        access("R5 page write", 13'h006, 2'b10, 1'b1, 1'b1, 16'hc300);
        access("R5 page read", 13'h006, 2'b11, 1'b0, 1'b1, 16'h0);
        ev0 = ev_cnt;
        ras_close();
        chk("R6 no refresh after access", ev_cnt, ev0);

        // R6: row-only refresh
        ctr0 = rfsh_ctr;
        ras_open(13'h1abc);
        ras_close();
        chk("R6 one event", ev_cnt, ev0 + 1);
        chk("R6 kind", 32'(ev_cbr), 0);
        chk("R6 row", 32'(ev_row), 32'h1abc);
        chk("R6 counter unchanged", 32'(rfsh_ctr), 32'(ctr0));

        // R7 R9: counter refreshes, address ignored, no error
        for (int i = 0; i < 3; i++) begin
            ev0 = ev_cnt;
            addr = 13'h0fff;
            cas_lo_n = 1'b0; cas_hi_n = 1'b0; settle(4);
            ras_n = 1'b0; settle(4);
            chk("R7 event", ev_cnt, ev0 + 1);
            chk("R7 kind", 32'(ev_cbr), 1);
            chk("R7 row from counter", 32'(ev_row), i);
            chk("R7 counter step", 32'(rfsh_ctr), i + 1);
            chk("R7 no drive", 32'(dout_en), 0);
            ras_close();
            cas_release();
            chk("R9 clean counter refresh", 32'(proto_err), 0);
        end

        // R8: hidden refresh keeps read data driven
        ras_open(13'h0a5);
        addr = 13'h003; we_n = 1'b1; oe_n = 1'b0;
        cas_lo_n = 1'b0; cas_hi_n = 1'b0; settle(4);
        chk("R8 read data", 32'(dout), 32'(model[widx(13'h0a5, 13'h003)]));
        ev0 = ev_cnt;
        ras_n = 1'b1; settle(4);
        chk("R8 drive through row high", 32'(dout_en), 3);
        chk("R8 no row-only refresh", ev_cnt, ev0);
        ras_n = 1'b0; settle(4);
        chk("R8 counter refresh", 32'(ev_cnt), ev0 + 1);
        chk("R8 kind", 32'(ev_cbr), 1);
        chk("R8 row", 32'(ev_row), 3);
        chk("R8 data held", 32'(dout), 32'(model[widx(13'h0a5, 13'h003)]));
        chk("R8 drive held", 32'(dout_en), 3);
        ras_close();
        chk("R8 drive after row up", 32'(dout_en), 3);
        cas_release();
        chk("R8 released", 32'(dout_en), 0);

        // R9: column pulse with no row strobe
        cas_lo_n = 1'b0; settle(4);
        chk("R9 not yet", 32'(proto_err), 0);
        cas_lo_n = 1'b1; settle(4);
        chk("R9 set", 32'(proto_err), 1);
        settle(6);
        chk("R9 sticky", 32'(proto_err), 1);
        ras_open(13'h0042);
        chk("R9 cleared by row fall", 32'(proto_err), 0);
        ras_close();

        // R2 R3 R4 R5: random page cycles against the model
        for (int p = 0; p < 80; p++) begin
            int n;
            ev0 = ev_cnt;
            ras_open(AW'($urandom));
            n = 1 + int'($urandom_range(0, 2));
            for (int a = 0; a < n; a++) begin
                logic [1:0] ln;
                ln = 2'($urandom_range(1, 3));
                access("R5 random", AW'($urandom), ln, 1'($urandom),
                       ($urandom_range(0, 7) != 0), 16'($urandom));
            end
            ras_close();
            chk("R6 random pages no refresh", ev_cnt, ev0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule